// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block decides when a small microcontroller drops into its deepest low-power state and how it comes back. A one-cycle sleep strobe from the core is accepted only if three configuration bits agree at that moment: standby selected, low-speed operation not selected, and the timer clock mode off. Once accepted, the block stops the system clock to the core and peripherals, switches the oscillator off and floats every I/O output driver. No register reset is ever issued, so all state in the chip is kept.

The block leaves standby in one of two ways. The first is an interrupt request from one of the wake sources (two external interrupt lines and eight wakeup pins). That request counts only while the global interrupt mask is clear and the source's own enable bit is set. The oscillator restarts and a down-counter waits for a settling time chosen by a 3-bit code. Only then does the clock return to the whole chip, with a one-cycle interrupt-exception pulse. Operation resumes at high or medium speed, as the speed-select input directs. The second way is the reset pin going low. The oscillator and clock start at once, but the reset-exception pulse waits until the pin is released. Reset-pin low takes precedence in every state.

Top module: `standby_ctrl`

## Requirements
- R1: When sleep_i is 1 in active mode with stby_sel_i=1, lowspd_sel_i=0 and tmr_mode_i=0, the block is in standby from the next clock. Any other combination at the strobe leaves it in active mode, and mode_o is unchanged.
- R2: In standby and during settling, clk_gate_en_o=0 and io_hiz_o=1. In active mode, clk_gate_en_o=1 and io_hiz_o=0. osc_en_o=0 only in standby.
- R3: In standby, a request on any bit of wake_req_i that has its wake_en_i bit set, while irq_mask_i=0, starts settling from the next clock, with osc_en_o=1 and the clock still gated. Bits 1:0 are the external interrupt lines and bits 9:2 are the wakeup pins.
- R4: A standby request whose enable bit is 0, or any request while irq_mask_i=1, is ignored: mode_o stays 2 and osc_en_o stays 0.
- R5: Settling lasts N clocks, where settle_sel_i codes 0..7 give N = 8192, 16384, 32768, 65536, 131072, 2, 8 and 16. The code is sampled at the wake. In the clock after the last settling clock, the clock is restored and irq_exc_o is 1 for exactly one cycle.
- R6: mode_o encodes 0 = active high-speed, 1 = active medium-speed, 2 = standby. From the interrupt-exception cycle onward, active mode is medium-speed if med_sel_i=1 in that cycle, otherwise high-speed.
- R7: res_pin_ni=0 puts the block in reset hold from the next clock, from any state: osc_en_o=1, clk_gate_en_o=1, io_hiz_o=1, mode_o=0. rst_exc_o is 1 in the hold cycle in which the pin is back high. Active high-speed mode follows.
- R8: Reset-pin low wins over an interrupt wake pending in the same cycle and aborts settling; no irq_exc_o pulse results.
- R9: irq_exc_o rises only after settling, and rst_exc_o only after the reset pin was low.
- R10: After rst_ni, the block is in active high-speed mode with the clock enabled, outputs driven and no exception pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-domain clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sleep_i | input | 1 | Sleep strobe from the core |
| stby_sel_i | input | 1 | Standby selected |
| lowspd_sel_i | input | 1 | Low-speed operation selected |
| tmr_mode_i | input | 1 | Timer clock mode bit |
| med_sel_i | input | 1 | Medium-speed resume select |
| settle_sel_i | input | 3 | Settling time code |
| irq_mask_i | input | 1 | Global interrupt mask |
| wake_req_i | input | NUM_SRC | Wake source requests |
| wake_en_i | input | NUM_SRC | Per-source enables |
| res_pin_ni | input | 1 | Reset pin, active low |
| osc_en_o | output | 1 | Oscillator run enable |
| clk_gate_en_o | output | 1 | System clock enable |
| io_hiz_o | output | 1 | Float all I/O output enables |
| irq_exc_o | output | 1 | Interrupt exception start pulse |
| rst_exc_o | output | 1 | Reset exception start pulse |
| mode_o | output | 2 | Current operating mode |

## Verification
The bench attacks the entry match by applying the strobe with each of the three bits wrong in turn; a design that checked only some of the bits would drop into standby. It offers masked and disabled requests in standby, which a design that ignored the qualifiers would answer by waking. It measures the settling delay for short and long codes, which catches off-by-one counting and a wrong decode. It also pulls the reset pin during settling and together with a pending wake; a design with the wrong priority would emit an interrupt pulse or leave the clock gated.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE, ST_STANDBY, ST_SETTLE, ST_RESUME, ST_RST_HOLD
  } stby_state_e;

  typedef enum logic [1:0] {
    MODE_HIGH = 2'd0,
    MODE_MED  = 2'd1,
    MODE_STBY = 2'd2
  } mode_e;

  // codes 0..4: 2^(13+code); 5..7 short waits
  function automatic int unsigned settle_len(input logic [2:0] code);
    case (code)
      3'd5:    return 2;
      3'd6:    return 8;
      3'd7:    return 16;
      default: return 32'd1 << (13 + int'(code));
    endcase
  endfunction
endpackage

// File: rtl/stby_wake_qual.sv
module stby_wake_qual #(
  parameter int NUM_SRC = 10
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               mask_i,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = req_i[i] & en_i[i];
  end

  assign wake_o = !mask_i && (|hit);
endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt
  import stby_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(settle_len(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (load_i)                          cnt_q <= load_val;
    else if (run_i && cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(1));

  // R5: counter never empty while settling
  a_r5_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sleep_i,
  input  logic        stby_sel_i,
  input  logic        lowspd_sel_i,
  input  logic        tmr_mode_i,
  input  logic        med_sel_i,
  input  logic        res_pin_ni,
  input  logic        wake_i,
  input  logic        settle_done_i,
  output logic        load_o,
  output logic        run_o,
  output logic        osc_en_o,
  output logic        clk_gate_en_o,
  output logic        io_hiz_o,
  output logic        irq_exc_o,
  output logic        rst_exc_o,
  output logic [1:0]  mode_o
);
  stby_state_e st_q, st_d;
  logic        med_q;
  logic        entry_ok;
  mode_e       mode;

  assign entry_ok = stby_sel_i && !lowspd_sel_i && !tmr_mode_i;

  always_comb begin
    st_d = st_q;
    if (!res_pin_ni) st_d = ST_RST_HOLD;
    else begin
      case (st_q)
        ST_ACTIVE:   if (sleep_i && entry_ok) st_d = ST_STANDBY;
        ST_STANDBY:  if (wake_i) st_d = ST_SETTLE;
        ST_SETTLE:   if (settle_done_i) st_d = ST_RESUME;
        ST_RESUME:   st_d = ST_ACTIVE;
        ST_RST_HOLD: st_d = ST_ACTIVE;
        default:     st_d = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ACTIVE;
      med_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RST_HOLD)    med_q <= 1'b0;
      else if (st_q == ST_RESUME) med_q <= med_sel_i;
    end
  end

  assign load_o = (st_q == ST_STANDBY) && res_pin_ni && wake_i;
  assign run_o  = (st_q == ST_SETTLE);

  always_comb begin
    osc_en_o      = 1'b1;
    clk_gate_en_o = 1'b1;
    io_hiz_o      = 1'b0;
    irq_exc_o     = 1'b0;
    rst_exc_o     = 1'b0;
    mode          = med_q ? MODE_MED : MODE_HIGH;
    case (st_q)
      ST_STANDBY: begin
        osc_en_o      = 1'b0;
        clk_gate_en_o = 1'b0;
        io_hiz_o      = 1'b1;
        mode          = MODE_STBY;
      end
      ST_SETTLE: begin
        clk_gate_en_o = 1'b0;
        io_hiz_o      = 1'b1;
        mode          = MODE_STBY;
      end
      ST_RESUME: begin
        irq_exc_o = 1'b1;
        mode      = med_sel_i ? MODE_MED : MODE_HIGH;
      end
      ST_RST_HOLD: begin
        io_hiz_o  = 1'b1;
        rst_exc_o = res_pin_ni;
        mode      = MODE_HIGH;
      end
      default: ;
    endcase
  end

  assign mode_o = mode;

  // R1: no entry without the full config match
  a_r1_no_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACTIVE && res_pin_ni && !entry_ok) |=> (st_q != ST_STANDBY));
  // R3: settling only follows standby
  a_r3_settle_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> ($past(st_q) == ST_STANDBY));
  // R5: single-cycle interrupt exception
  a_r5_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_exc_o |=> !irq_exc_o);
  // R7: reset pin overrides every state
  a_r7_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_pin_ni |=> (st_q == ST_RST_HOLD));
  // R9: reset exception only after pin was low
  a_r9_rst_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_exc_o |-> $past(!res_pin_ni));
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import stby_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int CNT_W   = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_i,
  input  logic               stby_sel_i,
  input  logic               lowspd_sel_i,
  input  logic               tmr_mode_i,
  input  logic               med_sel_i,
  input  logic [2:0]         settle_sel_i,
  input  logic               irq_mask_i,
  input  logic [NUM_SRC-1:0] wake_req_i,
  input  logic [NUM_SRC-1:0] wake_en_i,
  input  logic               res_pin_ni,
  output logic               osc_en_o,
  output logic               clk_gate_en_o,
  output logic               io_hiz_o,
  output logic               irq_exc_o,
  output logic               rst_exc_o,
  output logic [1:0]         mode_o
);
  logic wake, load, run, done;

  stby_wake_qual #(.NUM_SRC(NUM_SRC)) u_qual (
    .req_i  (wake_req_i),
    .en_i   (wake_en_i),
    .mask_i (irq_mask_i),
    .wake_o (wake)
  );

  stby_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .run_i  (run),
    .sel_i  (settle_sel_i),
    .done_o (done)
  );

  stby_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_i       (sleep_i),
    .stby_sel_i    (stby_sel_i),
    .lowspd_sel_i  (lowspd_sel_i),
    .tmr_mode_i    (tmr_mode_i),
    .med_sel_i     (med_sel_i),
    .res_pin_ni    (res_pin_ni),
    .wake_i        (wake),
    .settle_done_i (done),
    .load_o        (load),
    .run_o         (run),
    .osc_en_o      (osc_en_o),
    .clk_gate_en_o (clk_gate_en_o),
    .io_hiz_o      (io_hiz_o),
    .irq_exc_o     (irq_exc_o),
    .rst_exc_o     (rst_exc_o),
    .mode_o        (mode_o)
  );

  // R4: masked request keeps oscillator off in standby
  a_r4_masked_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && mode_o == 2'd2 && res_pin_ni && irq_mask_i) |=> !osc_en_o);
  // R2: gated clock always with floated I/O
  a_r2_hiz_when_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_gate_en_o |-> io_hiz_o);
endmodule

// File: tb/tb_standby_ctrl.sv
`timescale 1ns/1ps
module tb_standby_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 10;

  logic clk = 0, rst_n = 0;
  logic sleep = 0, stby_sel = 1, lowspd = 0, tmr = 0, med_sel = 0;
  logic [2:0] sel = 3'd5;
  logic mask = 0, res_n = 1;
  logic [NSRC-1:0] req = '0, en = '0;
  logic osc_en, clk_en, hiz, irq_exc, rst_exc;
  logic [1:0] mode;

  int total = 0, bad = 0;
  int irq_cnt = 0, rst_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_ctrl #(.NUM_SRC(NSRC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .stby_sel_i(stby_sel),
    .lowspd_sel_i(lowspd), .tmr_mode_i(tmr), .med_sel_i(med_sel),
    .settle_sel_i(sel), .irq_mask_i(mask), .wake_req_i(req), .wake_en_i(en),
    .res_pin_ni(res_n), .osc_en_o(osc_en), .clk_gate_en_o(clk_en),
    .io_hiz_o(hiz), .irq_exc_o(irq_exc), .rst_exc_o(rst_exc), .mode_o(mode)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic int need_len(input int code);
    int t[8] = '{8192, 16384, 32768, 65536, 131072, 2, 8, 16};
    return t[code];
  endfunction

  // reference model: 0 active, 1 standby, 2 settling, 3 resume, 4 reset hold
  int m_st = 0, m_el = 0, m_need = 0, m_med = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_el = 0; m_med = 0;
    end else if (!res_n) m_st = 4;
    else begin
      case (m_st)
        0: if (sleep && stby_sel && !lowspd && !tmr) m_st = 1;
        1: if (!mask && (req & en) != 0) begin
             m_st = 2; m_el = 0; m_need = need_len(int'(sel));
           end
        2: begin m_el++; if (m_el == m_need) m_st = 3; end
        3: begin m_med = med_sel; m_st = 0; end
        default: begin m_med = 0; m_st = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int e_osc, e_clk, e_hiz, e_irq, e_rst, e_mode;
      e_osc = (m_st != 1); e_clk = (m_st != 1 && m_st != 2);
      e_hiz = (m_st == 1 || m_st == 2 || m_st == 4);
      e_irq = (m_st == 3); e_rst = (m_st == 4 && res_n);
      case (m_st)
        1, 2: e_mode = 2;
        3: e_mode = med_sel;
        4: e_mode = 0;
        default: e_mode = m_med;
      endcase
      chk("R2", "clk_gate_en", int'(clk_en), e_clk);
      chk("R2", "io_hiz", int'(hiz), e_hiz);
      chk("R3", "osc_en", int'(osc_en), e_osc);
      chk("R5", "irq_exc", int'(irq_exc), e_irq);
      chk("R7", "rst_exc", int'(rst_exc), e_rst);
      chk("R6", "mode", int'(mode), e_mode);
      irq_cnt += int'(irq_exc);
      rst_cnt += int'(rst_exc);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_standby();
    @(negedge clk); sleep = 1; stby_sel = 1; lowspd = 0; tmr = 0;
    @(negedge clk); sleep = 0;
  endtask

  // drive one enabled source, count negedges until the interrupt pulse
  task automatic wake_and_time(input int src, input int code, input bit med);
    int k;
    med_sel = med; sel = 3'(code); en = '0; en[src] = 1'b1;
    @(negedge clk); req = '0; req[src] = 1'b1;
    k = 0;
    @(negedge clk); req = '0;
    do begin
      #2; k++;
      if (irq_exc) break;
      @(negedge clk);
    end while (k < 140000);
    chk("R5", "settle cycles+1", k, need_len(code) + 1);
    tick(1);
    chk("R6", "resume speed", int'(mode), int'(med));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    #2;
    chk("R10", "mode after reset", int'(mode), 0);
    chk("R10", "clk after reset", int'(clk_en), 1);
    chk("R10", "hiz after reset", int'(hiz), 0);
    chk("R10", "pulses after reset", int'(irq_exc | rst_exc), 0);

    // R1 negatives: each bit wrong
    @(negedge clk); sleep = 1; lowspd = 1;
    @(negedge clk); sleep = 0; lowspd = 0; #2;
    chk("R1", "lowspd blocks entry", int'(mode), 0);
    @(negedge clk); sleep = 1; tmr = 1;
    @(negedge clk); sleep = 0; tmr = 0; #2;
    chk("R1", "timer bit blocks entry", int'(mode), 0);
    @(negedge clk); sleep = 1; stby_sel = 0;
    @(negedge clk); sleep = 0; stby_sel = 1; #2;
    chk("R1", "no standby select", int'(mode), 0);

    enter_standby(); #2;
    chk("R1", "entered standby", int'(mode), 2);

    // R4: disabled source, then masked enabled source
    @(negedge clk); en = 10'b0000000001; req = 10'b0000000010;
    tick(4); #2;
    chk("R4", "disabled source ignored", int'(osc_en), 0);
    @(negedge clk); mask = 1; req = 10'b0000000001;
    tick(4); #2;
    chk("R4", "masked request ignored", int'(mode), 2);
    @(negedge clk); mask = 0; req = '0;

    // R3/R5/R6 wakes
    wake_and_time(0, 5, 1'b1);
    enter_standby();
    wake_and_time(5, 7, 1'b0);
    enter_standby();
    wake_and_time(9, 6, 1'b1);
    enter_standby();
    wake_and_time(1, 0, 1'b0);

    // R7: reset pin from active
    irq_cnt = 0; rst_cnt = 0;
    @(negedge clk); res_n = 0;
    tick(1); #2;
    chk("R7", "hold clock on", int'(clk_en), 1);
    chk("R7", "hold osc on", int'(osc_en), 1);
    chk("R7", "no early rst_exc", int'(rst_exc), 0);
    tick(2); res_n = 1; #2;
    chk("R7", "rst_exc on release", int'(rst_exc), 1);
    tick(2);
    chk("R7", "one rst pulse", rst_cnt, 1);
    chk("R7", "back to high speed", int'(mode), 0);

    // R8: reset during settling
    enter_standby();
    @(negedge clk); sel = 3'd0; en = '1; req = 10'b0000100000;
    @(negedge clk); req = '0;
    tick(100);
    irq_cnt = 0;
    res_n = 0;
    tick(1); #2;
    chk("R8", "settling aborted", int'(mode), 0);
    chk("R8", "clock on in hold", int'(clk_en), 1);
    tick(1); res_n = 1;
    tick(3);
    chk("R8", "no irq after abort", irq_cnt, 0);

    // R8/R9: reset and wake in same cycle
    enter_standby();
    irq_cnt = 0; rst_cnt = 0;
    @(negedge clk); sel = 3'd5; req = 10'b0000000001; res_n = 0;
    @(negedge clk); req = '0; res_n = 1;
    tick(6);
    chk("R9", "no irq_exc on reset path", irq_cnt, 0);
    chk("R9", "rst_exc from pin", rst_cnt, 1);
    chk("R8", "active after reset", int'(mode), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule